// File: doc/BRIEF.md
# Synchronous Character Transmitter with End-of-Message Control

This block serialises 8-bit characters handed over by a host onto a synchronous line and keeps the line busy when the host falls behind. A one-character holding register sits in front of a shift register. A new character starts on the first clock after the transmitter is enabled, and after that on each bit-enable pulse that completes a character. While a message is in progress, a CRC-16 accumulates over every data character.

A latched end-of-message flag decides what happens when a character slot comes up with nothing in the holding register. If the flag is set, the block fills the slot with the programmable sync character and keeps it out of the CRC. If the host has cleared the flag and a message is open, the block appends the two CRC bytes, followed by one sync character, and then sets the flag again. Each time the flag goes from clear to set, the interrupt level is raised. The interrupt level is raised again when the sync character that follows a CRC is loaded. Data the host writes while a CRC is going out waits until that sync character has been sent and then opens a new message.

Top module: `sync_tx_eom`

## Requirements
- R1: After reset, txd is 1, buffer_empty is 1, eom_flag is 1, irq is 0 and the sync character is 0x16.
- R2: While tx_en is 0, txd stays 1 and no character is taken from the holding register, whatever bit_en does.
- R3: A data write while the holding register is full is ignored. The earlier character is the one that is sent.
- R4: Characters go out MSB first, one bit per bit_en pulse, with no gap between them. The first character is loaded on the clock after tx_en rises.
- R5: An empty slot with eom_flag set is filled with the current sync character. A sync_wr applies from the next character load. Filled syncs do not enter the CRC and do not end the open message.
- R6: An empty slot with eom_flag clear and a message open sends the CRC. The CRC is x^16+x^15+x^2+1, preset to 0 at the message's first data character, and taken MSB first over its data characters. It goes out high byte first, then the low byte, then one sync character. eom_flag is set when the CRC high byte is loaded.
- R7: While either CRC byte is in the shift register, eom_flag reads 1 and buffer_empty reads 0. When the sync character after the CRC is loaded, buffer_empty returns to 1 if no data is held.
- R8: irq rises in the same cycle that eom_flag goes from 0 to 1, and also when the post-CRC sync character is loaded. It stays 1 until irq_ack. A set in the same cycle as irq_ack wins.
- R9: An empty slot with eom_flag clear and no message open sends a sync character and sets eom_flag. irq goes to 1 at that load, and buffer_empty reads 1.
- R10: Data written while the CRC is being sent is held. It goes out after the CRC and one sync character, and it starts a fresh CRC.
- R11: eom_clear clears eom_flag at any point in a message. A CRC that starts in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; 0 stops and idles the line |
| bit_en | input | 1 | One-cycle pulse per line bit |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | 8 | Character to send |
| sync_wr | input | 1 | Sync character write strobe |
| sync_data | input | 8 | New sync character |
| eom_clear | input | 1 | Clears the end-of-message flag |
| irq_ack | input | 1 | Clears the interrupt level |
| txd | output | 1 | Serial data out |
| buffer_empty | output | 1 | Holding register free and no CRC in progress |
| eom_flag | output | 1 | End-of-message / underrun flag |
| irq | output | 1 | Interrupt level |

## Verification
The bench goes through message lengths one to four. In each case it clears the flag either before the first data character is loaded or after it, and the recovered CRC bytes are checked against a bitwise CRC computed in the bench. A design that seeded the CRC at the wrong character, or that folded sync-filled slots into the CRC, would send wrong CRC bytes. The bench also samples status and interrupt at the loads of the CRC bytes, the post-CRC sync and a flag-setting sync fill. A design that dropped data written during the CRC, or that skipped the separating sync, would produce a character stream that differs from the one the bench expects. So would a design that raised the interrupt on a fill while the flag was already set.

// File: rtl/sync_tx_eom.sv
module sync_tx_eom #(
  parameter int CHAR_W = 8,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8005,
  parameter logic [CHAR_W-1:0] SYNC_INIT = 8'h16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_en,
  input  logic              wr_valid,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              sync_wr,
  input  logic [CHAR_W-1:0] sync_data,
  input  logic              eom_clear,
  input  logic              irq_ack,
  output logic              txd,
  output logic              buffer_empty,
  output logic              eom_flag,
  output logic              irq
);

  localparam int CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAR_W - 1);

  typedef enum logic [2:0] {
    PICK_NONE, PICK_CRC_LO, PICK_END_SYNC, PICK_DATA, PICK_CRC_HI, PICK_FILL
  } pick_t;

  logic [CHAR_W-1:0] hold_q, shift_q, sync_q;
  logic              hold_full, running, crc_busy, crc_lo_next, msg_open;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CRC_W-1:0]  crc_q;
  logic              eom_q, irq_q;
  logic              slot;
  pick_t             pick;
  logic              eom_set, irq_set, fill_sync;

  function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c,
                                                input logic [CHAR_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = CHAR_W - 1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else                   r = r << 1;
    end
    return r;
  endfunction

  assign slot = tx_en && (running ? (bit_en && bit_cnt == LAST_BIT) : 1'b1);

  always_comb begin
    pick = PICK_NONE;
    if (slot) begin
      if (crc_busy && !crc_lo_next)  pick = PICK_CRC_LO;
      else if (crc_busy)             pick = PICK_END_SYNC;
      else if (hold_full)            pick = PICK_DATA;
      else if (!eom_q && msg_open)   pick = PICK_CRC_HI;
      else                           pick = PICK_FILL;
    end
  end

  assign fill_sync = (pick == PICK_FILL) || (pick == PICK_END_SYNC);
  assign eom_set   = !eom_q && ((pick == PICK_CRC_HI) || (pick == PICK_FILL));
  assign irq_set   = eom_set || (pick == PICK_END_SYNC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running     <= 1'b0;
      bit_cnt     <= '0;
      shift_q     <= '0;
      crc_busy    <= 1'b0;
      crc_lo_next <= 1'b0;
      msg_open    <= 1'b0;
      crc_q       <= '0;
    end else if (!tx_en) begin
      running     <= 1'b0;
      bit_cnt     <= '0;
      crc_busy    <= 1'b0;
      crc_lo_next <= 1'b0;
    end else if (slot) begin
      running <= 1'b1;
      bit_cnt <= '0;
      case (pick)
        PICK_CRC_LO: begin
          shift_q     <= crc_q[CHAR_W-1:0];
          crc_lo_next <= 1'b1;
        end
        PICK_END_SYNC: begin
          shift_q     <= sync_q;
          crc_busy    <= 1'b0;
          crc_lo_next <= 1'b0;
        end
        PICK_DATA: begin
          shift_q  <= hold_q;
          crc_q    <= crc_next(msg_open ? crc_q : '0, hold_q);
          msg_open <= 1'b1;
        end
        PICK_CRC_HI: begin
          shift_q  <= crc_q[CRC_W-1:CRC_W-CHAR_W];
          crc_busy <= 1'b1;
          msg_open <= 1'b0;
        end
        default: shift_q <= sync_q;
      endcase
    end else if (running && bit_en) begin
      shift_q <= {shift_q[CHAR_W-2:0], 1'b0};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (pick == PICK_DATA) begin
      hold_full <= 1'b0;
    end else if (wr_valid && !hold_full) begin
      hold_full <= 1'b1;
      hold_q    <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= SYNC_INIT;
      eom_q  <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      if (sync_wr) sync_q <= sync_data;
      if (eom_set)        eom_q <= 1'b1;
      else if (eom_clear) eom_q <= 1'b0;
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_ack)   irq_q <= 1'b0;
    end
  end

  assign txd          = running ? shift_q[CHAR_W-1] : 1'b1;
  assign buffer_empty = !hold_full && !crc_busy;
  assign eom_flag     = eom_q;
  assign irq          = irq_q;

  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txd);
  a_r4_txd_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running && !$past(bit_en)) |-> $stable(txd));
  a_r5_fill_keeps_crc: assert property (@(posedge clk) disable iff (!rst_n)
    fill_sync |=> $stable(crc_q));
  a_r8_irq_on_eom_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eom_flag) |-> irq);
  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  a_r11_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (eom_clear && !eom_set) |=> !eom_flag);
  a_r7_crc_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pick == PICK_CRC_HI) |=> (!buffer_empty && eom_flag));

endmodule

// File: tb/sync_tx_eom_bench.sv
`timescale 1ns/1ps
module sync_tx_eom_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, bit_en = 1'b0, wr_valid = 1'b0, sync_wr = 1'b0;
  logic eom_clear = 1'b0, irq_ack = 1'b0;
  logic [7:0] wr_data = '0, sync_data = '0;
  logic txd, buffer_empty, eom_flag, irq;
  int checks = 0, errors = 0;
  logic [7:0] sync_now = 8'h16;

  sync_tx_eom u_sync_tx_eom (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_en(bit_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .sync_wr(sync_wr),
    .sync_data(sync_data), .eom_clear(eom_clear), .irq_ack(irq_ack),
    .txd(txd), .buffer_empty(buffer_empty), .eom_flag(eom_flag), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb = r[15] ^ d[k];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'b1000_0000_0000_0101;
    end
    return r;
  endfunction

  task automatic bit_step(output logic b);
    b = txd;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic get_char(input string req, input logic [7:0] exp);
    logic [7:0] c;
    logic b;
    for (int k = 7; k >= 0; k--) begin
      bit_step(b);
      c[k] = b;
    end
    check(req, c, exp);
  endtask

  task automatic put(input logic [7:0] d);
    wr_data = d; wr_valid = 1'b1; @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic clear_eom();
    eom_clear = 1'b1; @(negedge clk); eom_clear = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic set_sync(input logic [7:0] s);
    sync_data = s; sync_wr = 1'b1; @(negedge clk); sync_wr = 1'b0;
  endtask

  task automatic crc_tail(input logic [15:0] c, input logic [7:0] s);
    check("R7 eom during crc", eom_flag, 1);
    check("R7 empty low during crc", buffer_empty, 0);
    check("R8 irq at eom set", irq, 1);
    ack();
    check("R8 irq cleared by ack", irq, 0);
    get_char("R6 crc high byte", c[15:8]);
    check("R7 empty low on crc low", buffer_empty, 0);
    get_char("R6 crc low byte", c[7:0]);
    check("R7 empty after crc", buffer_empty, 1);
    check("R8 irq after crc", irq, 1);
    ack();
    get_char("R6 sync after crc", s);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R4 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic b;
    logic [15:0] crc;
    logic [7:0] d [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd", txd, 1);
    check("R1 empty", buffer_empty, 1);
    check("R1 eom", eom_flag, 1);
    check("R1 irq", irq, 0);

    put(8'h5A);
    put(8'hC3);
    check("R3 full after write", buffer_empty, 0);
    for (int k = 0; k < 4; k++) begin
      bit_step(b);
      check("R2 idle while disabled", b, 1);
    end
    tx_en = 1'b1;
    @(negedge clk);
    get_char("R3 first write kept, R4 msb first", 8'h5A);
    check("R5 no irq on fill with flag set", irq, 0);
    get_char("R5 fill sync", 8'h16);
    set_sync(8'h7E);
    get_char("R5 fill old sync", 8'h16);
    get_char("R5 new sync", 8'h7E);
    set_sync(8'h16);
    clear_eom();
    check("R11 eom cleared", eom_flag, 0);
    get_char("R5 sync before crc", 8'h7E);
    crc_tail(crc_ref(16'h0, 8'h5A), 8'h16);

    for (int len = 1; len <= 4; len++) begin
      for (int pos = 0; pos < 2; pos++) begin
        crc = 16'h0;
        for (int i = 0; i < len; i++) begin
          d[i] = 8'(len * 37 + i * 91 + pos * 13);
          crc = crc_ref(crc, d[i]);
        end
        if (pos == 0) begin
          clear_eom();
          check("R11 clear before data", eom_flag, 0);
        end
        put(d[0]);
        get_char("R4 sync ahead of message", 8'h16);
        if (pos == 1) begin
          clear_eom();
          check("R11 clear after first char", eom_flag, 0);
        end
        for (int i = 1; i < len; i++) begin
          put(d[i]);
          get_char("R4 data char", d[i-1]);
        end
        get_char("R4 last data char", d[len-1]);
        crc_tail(crc, 8'h16);
      end
    end

    put(8'hA1);
    get_char("R5 sync", 8'h16);
    get_char("R5 data a", 8'hA1);
    get_char("R5 fill inside message", 8'h16);
    put(8'h3C);
    get_char("R5 fill inside message", 8'h16);
    clear_eom();
    get_char("R5 data b", 8'h3C);
    crc_tail(crc_ref(crc_ref(16'h0, 8'hA1), 8'h3C), 8'h16);

    clear_eom();
    check("R9 eom cleared", eom_flag, 0);
    check("R9 no irq yet", irq, 0);
    get_char("R9 sync", 8'h16);
    check("R9 eom set by fill", eom_flag, 1);
    check("R9 irq on fill", irq, 1);
    check("R9 empty on fill", buffer_empty, 1);
    ack();
    get_char("R9 next sync", 8'h16);

    put(8'h99);
    clear_eom();
    get_char("R10 sync", 8'h16);
    get_char("R10 data", 8'h99);
    check("R8 irq at crc", irq, 1);
    ack();
    put(8'hE7);
    get_char("R10 crc high", crc_ref(16'h0, 8'h99) >> 8);
    get_char("R10 crc low", crc_ref(16'h0, 8'h99) & 16'hFF);
    check("R10 held data keeps empty low", buffer_empty, 0);
    check("R8 irq after crc", irq, 1);
    ack();
    get_char("R10 one sync between", 8'h16);
    clear_eom();
    get_char("R10 held data", 8'hE7);
    crc_tail(crc_ref(16'h0, 8'hE7), 8'h16);

    tx_en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      bit_step(b);
      check("R2 idle after disable", b, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule